// File: doc/BRIEF.md
# Dual-Path Priority Interrupt Arbiter

This block picks one winning interrupt line for each of two independent request paths: a normal path and a fast path. Every line carries a pending bit, a mask bit, a fast-routing bit and a small priority value. The lines are grouped in one to three banks of 32. A line whose routing bit is clear competes on the normal path and a line whose routing bit is set competes on the fast path. The lowest priority value wins, and among equal values the higher line number wins.

Each path holds a re-arm flag, a registered winner number and a parent request output. When the flag is set, at least one candidate exists and the global enable is high, the path captures the winner, raises its parent request and clears its flag. It then ignores all further changes until software pulses that path's re-arm input. The pulse lowers the parent request, sets the flag again and re-evaluates in the same cycle. If a candidate is already waiting at that moment, the request stays high with the new winner. Both paths evaluate every cycle, so a newly latched pending bit or a mask change is seen on the next clock edge.

Top module: `irq_dual_arbiter`

## Requirements
- R1: A line is a normal-path candidate when its pending bit is 1, its mask bit is 0 and its fast-routing bit is 0. It is a fast-path candidate under the same conditions with a fast-routing bit of 1. A masked line never wins.
- R2: Among candidates, the lowest priority value wins (0 is the most urgent).
- R3: When candidates tie on the best priority, the one with the highest line number wins, both inside a bank and across banks.
- R4: The reported line number is 32 × bank + bit index, on a 7-bit output.
- R5: When a path's flag is set (or its re-arm input is high), a candidate exists and the global enable is 1, the next clock edge raises the parent request, registers the winner and clears the flag.
- R6: While a parent request is high and no re-arm pulse arrives, the request stays high and the line number holds, whatever the inputs do.
- R7: A re-arm pulse with no candidate (or with the global enable at 0) drops the parent request on the next edge, sets the flag and leaves the line number unchanged.
- R8: A re-arm pulse while a candidate exists fires again on the same edge: the request stays high and the line number becomes the new winner.
- R9: After reset both requests are 0, both line numbers are 0 and both flags are set, so the first candidate fires at once.
- R10: While the global enable is 0 no path fires. Raising it lets an armed path fire on the next edge.
- R11: The two paths are independent: a re-arm or a firing on one path leaves the other path's request and line number unchanged.
- R12: The number of banks is a parameter from 1 to 3. Lines in the highest bank (up to line 95) are arbitrated like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 32×NUM_BANKS | Latched pending bit per line |
| mask_i | input | 32×NUM_BANKS | Mask bit per line, 1 = masked |
| fast_sel_i | input | 32×NUM_BANKS | Routing bit per line, 1 = fast path |
| prio_i | input | 32×NUM_BANKS×PRIO_W | Priority per line, line n at bits n×PRIO_W upward |
| glb_en_i | input | 1 | Global enable, 1 = interrupts allowed |
| rearm_norm_i | input | 1 | One-cycle re-arm pulse for the normal path |
| rearm_fast_i | input | 1 | One-cycle re-arm pulse for the fast path |
| norm_req_o | output | 1 | Normal-path parent request |
| norm_line_o | output | 7 | Registered normal-path winner |
| fast_req_o | output | 1 | Fast-path parent request |
| fast_line_o | output | 7 | Registered fast-path winner |

## Verification
The assertions assume that the re-arm inputs are pulses that are low during reset. They also assume that the vector inputs are steady at each clock edge, because the winner is taken from them combinationally in the same cycle it is captured. The bench keeps to this by changing every input only on the falling edge and by holding each re-arm high for exactly one cycle. It samples on the following falling edge, after a single rising edge, so each fire, hold and drop is seen in the cycle it takes effect.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int BANK_LINES = 32;
   localparam int MAX_BANKS  = 3;
   localparam int LINE_W     = 7;
   localparam int NUM_PATHS  = 2;
   typedef enum logic {PATH_NORM = 1'b0, PATH_FAST = 1'b1} path_e;
endpackage

// File: rtl/irq_arb_tree.sv
// Balanced compare tree: each node keeps the more urgent child, and the
// right (higher-numbered) child on a tie.
module irq_arb_tree #(
   parameter int NUM_LINES = 32,
   parameter int PRIO_W    = 5,
   parameter int IDX_W     = 7
) (
   input  logic [NUM_LINES-1:0]        cand_i,
   input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
   output logic                        any_o,
   output logic [IDX_W-1:0]            win_o
);
   localparam int LVLS   = $clog2(NUM_LINES);
   localparam int LEAVES = 1 << LVLS;

   initial begin
      assert (LEAVES <= (1 << IDX_W))
         else $error("winner index width too small for %0d lines", NUM_LINES);
   end

   for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
      localparam int W = LEAVES >> l;
      logic [W-1:0]        vld;
      logic [W*PRIO_W-1:0] pri;
      logic [W*IDX_W-1:0]  idx;
      if (l == 0) begin : g_leaf
         for (genvar i = 0; i < W; i++) begin : g_in
            if (i < NUM_LINES) begin : g_real
               assign vld[i]                  = cand_i[i];
               assign pri[i*PRIO_W +: PRIO_W] = prio_i[i*PRIO_W +: PRIO_W];
               assign idx[i*IDX_W +: IDX_W]   = IDX_W'(i);
            end else begin : g_pad
               assign vld[i]                  = 1'b0;
               assign pri[i*PRIO_W +: PRIO_W] = '1;
               assign idx[i*IDX_W +: IDX_W]   = '0;
            end
         end
      end else begin : g_node
         for (genvar n = 0; n < W; n++) begin : g_cmp
            logic               lv, rv, take_r;
            logic [PRIO_W-1:0]  lp, rp;
            logic [IDX_W-1:0]   li, ri;
            assign lv = g_lvl[l-1].vld[2*n];
            assign rv = g_lvl[l-1].vld[2*n+1];
            assign lp = g_lvl[l-1].pri[(2*n)*PRIO_W +: PRIO_W];
            assign rp = g_lvl[l-1].pri[(2*n+1)*PRIO_W +: PRIO_W];
            assign li = g_lvl[l-1].idx[(2*n)*IDX_W +: IDX_W];
            assign ri = g_lvl[l-1].idx[(2*n+1)*IDX_W +: IDX_W];
            assign take_r = rv && (!lv || (rp <= lp));
            assign vld[n]                  = lv | rv;
            assign pri[n*PRIO_W +: PRIO_W] = take_r ? rp : lp;
            assign idx[n*IDX_W +: IDX_W]   = take_r ? ri : li;
         end
      end
   end

   assign any_o = g_lvl[LVLS].vld[0];
   assign win_o = g_lvl[LVLS].idx[IDX_W-1:0];
endmodule

// File: rtl/irq_arb_path.sv
// One request path: re-arm flag, registered winner, parent request.
module irq_arb_path #(
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_i,
   input  logic [IDX_W-1:0] win_i,
   input  logic             en_i,
   input  logic             rearm_i,
   output logic             req_o,
   output logic [IDX_W-1:0] line_o
);
   logic armed_q;
   logic fire;

   assign fire = (armed_q || rearm_i) && any_i && en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         req_o   <= 1'b0;
         line_o  <= '0;
      end else if (fire) begin
         armed_q <= 1'b0;
         req_o   <= 1'b1;
         line_o  <= win_i;
      end else if (rearm_i) begin
         armed_q <= 1'b1;
         req_o   <= 1'b0;
      end
   end

   // R5: an armed path with a candidate fires and captures the winner
   a_r5_fire: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && any_i && en_i) |=> (req_o && !armed_q && line_o == $past(win_i)));
   // R6: a raised request holds its state until re-armed
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !rearm_i) |=> (req_o && $stable(line_o)));
   // R7: a re-arm with nothing to serve drops the request and keeps the line
   a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rearm_i && !(any_i && en_i)) |=> (!req_o && armed_q && $stable(line_o)));
   // R10: a disabled path cannot raise its request
   a_r10_block: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !req_o) |=> !req_o);
   // R9: the flag and the request are never set together
   a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(armed_q && req_o));
endmodule

// File: rtl/irq_dual_arbiter.sv
module irq_dual_arbiter
   import irq_arb_pkg::*;
#(
   parameter int NUM_BANKS = 3,
   parameter int PRIO_W    = 5
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_BANKS*BANK_LINES-1:0]        pend_i,
   input  logic [NUM_BANKS*BANK_LINES-1:0]        mask_i,
   input  logic [NUM_BANKS*BANK_LINES-1:0]        fast_sel_i,
   input  logic [NUM_BANKS*BANK_LINES*PRIO_W-1:0] prio_i,
   input  logic                                 glb_en_i,
   input  logic                                 rearm_norm_i,
   input  logic                                 rearm_fast_i,
   output logic                                 norm_req_o,
   output logic [LINE_W-1:0]                    norm_line_o,
   output logic                                 fast_req_o,
   output logic [LINE_W-1:0]                    fast_line_o
);
   localparam int NL = NUM_BANKS * BANK_LINES;

   initial begin
      assert (NUM_BANKS >= 1 && NUM_BANKS <= MAX_BANKS)
         else $error("NUM_BANKS must be 1..%0d", MAX_BANKS);
      assert (PRIO_W >= 1) else $error("PRIO_W must be positive");
   end

   logic [NUM_PATHS-1:0][NL-1:0]     cand;
   logic [NUM_PATHS-1:0]             any, rearm, req;
   logic [NUM_PATHS-1:0][LINE_W-1:0] win, line;

   assign rearm[PATH_NORM] = rearm_norm_i;
   assign rearm[PATH_FAST] = rearm_fast_i;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [BANK_LINES-1:0] live;
      assign live = pend_i[b*BANK_LINES +: BANK_LINES] & ~mask_i[b*BANK_LINES +: BANK_LINES];
      assign cand[PATH_NORM][b*BANK_LINES +: BANK_LINES] =
         live & ~fast_sel_i[b*BANK_LINES +: BANK_LINES];
      assign cand[PATH_FAST][b*BANK_LINES +: BANK_LINES] =
         live & fast_sel_i[b*BANK_LINES +: BANK_LINES];
   end

   for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
      logic [NL-1:0] shifted;
      irq_arb_tree #(.NUM_LINES(NL), .PRIO_W(PRIO_W), .IDX_W(LINE_W)) u_tree (
         .cand_i (cand[p]),
         .prio_i (prio_i),
         .any_o  (any[p]),
         .win_o  (win[p])
      );
      irq_arb_path #(.IDX_W(LINE_W)) u_path (
         .clk     (clk),
         .rst_n   (rst_n),
         .any_i   (any[p]),
         .win_i   (win[p]),
         .en_i    (glb_en_i),
         .rearm_i (rearm[p]),
         .req_o   (req[p]),
         .line_o  (line[p])
      );
      assign shifted = cand[p] >> win[p];
      // R1: the tree's winner is always a candidate of its own path
      a_r1_win_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
         any[p] |-> shifted[0]);
      // R4: a raised request reports a line that exists
      a_r4_line_range: assert property (@(posedge clk) disable iff (!rst_n)
         req[p] |-> (int'(line[p]) < NL));
   end

   assign norm_req_o  = req[PATH_NORM];
   assign fast_req_o  = req[PATH_FAST];
   assign norm_line_o = line[PATH_NORM];
   assign fast_line_o = line[PATH_FAST];

   // R11: re-arming one path never disturbs the other path's outputs
   a_r11_indep: assert property (@(posedge clk) disable iff (!rst_n)
      (rearm_norm_i && !rearm_fast_i && fast_req_o) |=> (fast_req_o && $stable(fast_line_o)));
endmodule

// File: tb/test_irq_dual_arbiter.sv
`timescale 1ns/1ps
module test_irq_dual_arbiter;
   localparam int NB = 3;
   localparam int PW = 5;
   localparam int NL = NB * 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NL-1:0]    pend = '0, mask = '0, fsel = '0;
   logic [NL*PW-1:0] prio = '0;
   logic glb_en = 1'b1, rn = 1'b0, rf = 1'b0;
   logic norm_req, fast_req;
   logic [6:0] norm_line, fast_line;
   int errors = 0, checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   irq_dual_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW)) i_irq_dual_arbiter (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .fast_sel_i(fsel),
      .prio_i(prio), .glb_en_i(glb_en), .rearm_norm_i(rn), .rearm_fast_i(rf),
      .norm_req_o(norm_req), .norm_line_o(norm_line),
      .fast_req_o(fast_req), .fast_line_o(fast_line));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_prio(input int ln, input int v);
      prio[ln*PW +: PW] = PW'(v);
   endtask

   // one rising edge, ending on the next falling edge
   task automatic step();
      @(negedge clk);
   endtask

   task automatic pulse_norm();
      rn = 1'b1; step(); rn = 1'b0;
   endtask

   task automatic pulse_fast();
      rf = 1'b1; step(); rf = 1'b0;
   endtask

   task automatic t_reset();
      chk("R9 norm req after reset", norm_req, 0);
      chk("R9 fast req after reset", fast_req, 0);
      chk("R9 norm line after reset", norm_line, 0);
      chk("R9 fast line after reset", fast_line, 0);
      step();
      chk("R9 stays low without candidates", norm_req, 0);
   endtask

   task automatic t_basic_fire();
      pend[5] = 1'b1; step();
      chk("R5 normal fires", norm_req, 1);
      chk("R4 normal line 5", norm_line, 5);
      chk("R1 fast path stays low for normal line", fast_req, 0);
      pend[70] = 1'b1; step(); step();
      chk("R6 request held", norm_req, 1);
      chk("R6 line held at 5", norm_line, 5);
   endtask

   task automatic t_tie_rearm();
      pulse_norm();
      chk("R8 refire keeps request high", norm_req, 1);
      chk("R3 tie across banks picks 70", norm_line, 70);
      pend = '0; pulse_norm();
      chk("R7 rearm without candidate drops request", norm_req, 0);
      chk("R7 line unchanged after drop", norm_line, 70);
   endtask

   task automatic t_priority_mask();
      set_prio(10, 3); set_prio(40, 1); set_prio(90, 2);
      pend[10] = 1'b1; pend[40] = 1'b1; pend[90] = 1'b1; step();
      chk("R2 lowest value wins", norm_line, 40);
      mask[40] = 1'b1; pulse_norm();
      chk("R1 masked line skipped", norm_line, 90);
      chk("R8 request after refire", norm_req, 1);
   endtask

   task automatic t_fast_path();
      fsel[33] = 1'b1; pend[33] = 1'b1; step();
      chk("R1 fast candidate fires", fast_req, 1);
      chk("R4 fast line 33 (bank 1 bit 1)", fast_line, 33);
      chk("R11 normal line untouched by fast fire", norm_line, 90);
      pend[33] = 1'b0; pulse_fast();
      chk("R11 fast dropped", fast_req, 0);
      chk("R11 normal request kept", norm_req, 1);
      chk("R11 normal line kept", norm_line, 90);
   endtask

   task automatic t_global_enable();
      pend = '0; mask = '0; prio = '0;
      pulse_norm();
      chk("R7 normal low", norm_req, 0);
      glb_en = 1'b0; pend[2] = 1'b1; step(); step();
      chk("R10 disabled blocks firing", norm_req, 0);
      glb_en = 1'b1; step();
      chk("R10 enable lets armed path fire", norm_req, 1);
      chk("R10 fired line 2", norm_line, 2);
   endtask

   task automatic t_bank_tie_and_top();
      pend = '0; pulse_norm();
      set_prio(3, 4); set_prio(7, 4); pend[3] = 1'b1; pend[7] = 1'b1;
      step();
      chk("R3 tie inside a bank picks 7", norm_line, 7);
      pend = '0; pulse_norm();
      set_prio(95, 0); pend[95] = 1'b1; pend[7] = 1'b1; step();
      chk("R12 top line of bank 2 wins", norm_line, 95);
      pend[95] = 1'b0; pulse_norm();
      chk("R8 rearm with candidate picks 7", norm_line, 7);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NL; i++) prio[i*PW +: PW] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic_fire();
      t_tie_rearm();
      t_priority_mask();
      t_fast_path();
      t_global_enable();
      t_bank_tie_and_top();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule